// File: doc/BRIEF.md
# Dual-Register Host Bus Interface for a Character Display Controller

This block is the host-facing side of a character display controller. A host processor reaches it over a strobed parallel bus made of an enable strobe, a register-select line, a read/write line and an 8-bit data bus. Each strobe is sampled into the core clock domain. The access completes when the strobe falls. The register-select and read/write lines pick one of four accesses: writing an instruction, reading status (a busy flag and the address counter), writing the data register, or reading the data register.

The data register stands between the host and the display/character RAM. A data write is passed on to RAM at the address counter. A data read returns the byte already held in the register, and the register is then refilled from the next address. After every data access the address counter moves up or down by one. The instruction register cannot be read back. Completed instruction bytes are handed to an external decoder through a one-cycle valid output. That decoder can load the address counter, and each load also fetches a fresh byte. One instruction field selects between full-width transfers and split 4-bit transfers on the upper data lines.

Top module: `hostbus_dualreg`

## Requirements
- R1: After reset, `bus_doe` is 0, `bus_dout` is 0, `busy` is 0, `ir_valid` is 0, the address counter is 0 and the bus is in 8-bit mode.
- R2: A completed byte with select=0 and read/write=0 gives a one-cycle `ir_valid` pulse carrying the byte on `ir_code`, provided `busy` is low. `busy` then stays high for exactly `BUSY_CYCLES` clocks. A byte of this kind that completes while `busy` is high is dropped without a pulse.
- R3: A read with select=0 returns the status byte {busy, address counter[6:0]}, never an instruction code. `bus_doe` is high only while the strobe is high with read/write=1.
- R4: A completed byte with select=1 and read/write=0 produces exactly one `ram_we` pulse, with `ram_addr` equal to the address counter before the access and `ram_wdata` equal to the byte.
- R5: A read with select=1 returns the data register. The counter then steps, and the data register is refilled from RAM at the new counter value.
- R6: After each data access the address counter steps by +1 when `ac_down`=0 and by -1 when `ac_down`=1, wrapping modulo 128.
- R7: A one-cycle `ac_load` sets the counter to `ac_load_val` and refills the data register from that address. If `ac_load` arrives in the cycle where a data access is acted on, the RAM access uses the old counter and the counter ends at the loaded value. A strobe is acted on at the second rising edge after the first edge that samples the strobe low.
- R8: An accepted instruction whose bits [7:5] are 001 is a width command. Its bit 4 selects 8-bit mode (1) or 4-bit mode (0), effective from the next strobe.
- R9: In 4-bit mode each byte takes two strobes on data lines [7:4], upper nibble first. Input lines [3:0] are ignored and driven as 0 on reads. The access is acted on only at the second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Host enable strobe |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_din | input | 8 | Host data bus, inbound |
| bus_dout | output | 8 | Host data bus, outbound |
| bus_doe | output | 1 | Outbound bus drive enable |
| ir_valid | output | 1 | One-cycle pulse: accepted instruction byte |
| ir_code | output | 8 | Accepted instruction byte |
| ac_load | input | 1 | Load the address counter (from the decoder) |
| ac_load_val | input | 7 | Value for the address counter |
| ac_down | input | 1 | Step direction: 1 decrement, 0 increment |
| ram_addr | output | 7 | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read enable, data expected one cycle later |
| ram_rdata | input | 8 | RAM read data |
| busy | output | 1 | Busy flag |

## Verification
Two functions can fall in the same clock cycle: completing a host data write and a counter load from the decoder. The bench provokes this by raising `ac_load` exactly in the cycle where the strobe's falling edge is acted on, counted from the cycle the strobe was dropped. It then checks that the RAM write landed at the old counter value, that a status read shows the loaded value, and that the next data read returns the byte at the loaded address, which shows that the deferred refill used the loaded counter.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // Access kind, encoded as {select, read/write}
  typedef enum logic [1:0] {
    ACC_IR_WR   = 2'b00,
    ACC_STAT_RD = 2'b01,
    ACC_DR_WR   = 2'b10,
    ACC_DR_RD   = 2'b11
  } acc_e;

  // Width command: top three bits of the instruction byte, and the width bit
  localparam logic [2:0] WIDTH_CMD_TAG = 3'b001;
  localparam int         WIDTH_BIT     = 4;
endpackage

// File: rtl/hbus_rst_sync.sv
module hbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_in,
  input  logic          rs_in,
  input  logic          rw_in,
  input  logic [DW-1:0] d_in,
  output logic          e_hi,
  output logic          rs_now,
  output logic          rw_now,
  output logic          fall,
  output logic          cap_rs,
  output logic          cap_rw,
  output logic [DW-1:0] cap_d
);
  localparam int W = DW + 3;

  logic [STAGES-1:0][W-1:0] sh_q, sh_d;
  logic [W-1:0]             last;
  logic                     e_prev_q;
  logic [W-1:0]             cap_q;
  logic                     cap_en;

  always_comb begin
    sh_d[0] = {e_in, rs_in, rw_in, d_in};
    for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
  end

  assign last   = sh_q[STAGES-1];
  assign e_hi   = last[W-1];
  assign rs_now = last[W-2];
  assign rw_now = last[W-3];
  assign cap_en = e_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      e_prev_q <= 1'b0;
      cap_q    <= '0;
    end else begin
      sh_q     <= sh_d;
      e_prev_q <= e_hi;
      if (cap_en) cap_q <= last;
    end
  end

  assign fall   = e_prev_q & ~e_hi;
  assign cap_rs = cap_q[W-2];
  assign cap_rw = cap_q[W-3];
  assign cap_d  = cap_q[DW-1:0];

  // Each strobe completes exactly once
  a_r4_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/hbus_width_ctrl.sv
module hbus_width_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic [DW-1:0] cap_d,
  input  logic          mode_wr,
  input  logic          mode_wide,
  input  logic [DW-1:0] rd_byte,
  output logic          done,
  output logic [DW-1:0] byte_o,
  output logic [DW-1:0] dout
);
  localparam int HW = DW / 2;

  logic          wide_q, wide_d;
  logic          phase_q, phase_d;
  logic [HW-1:0] hi_q;
  logic          hi_en;

  assign done   = fall & (wide_q | phase_q);
  assign byte_o = wide_q ? cap_d : {hi_q, cap_d[DW-1:HW]};
  assign hi_en  = fall & ~wide_q & ~phase_q;

  always_comb begin
    wide_d  = wide_q;
    phase_d = phase_q;
    if (fall && !wide_q) phase_d = ~phase_q;
    if (mode_wr) begin
      wide_d  = mode_wide;
      phase_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= 1'b1;
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      wide_q  <= wide_d;
      phase_q <= phase_d;
      if (hi_en) hi_q <= cap_d[DW-1:HW];
    end
  end

  always_comb begin
    if (wide_q)       dout = rd_byte;
    else if (phase_q) dout = {rd_byte[HW-1:0], {HW{1'b0}}};
    else              dout = {rd_byte[DW-1:HW], {HW{1'b0}}};
  end

  a_r9_wide_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wide_q |-> !phase_q);
  a_r9_first_nibble_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !wide_q && !phase_q && !mode_wr) |=> phase_q);
endmodule

// File: rtl/hbus_busy_timer.sv
module hbus_busy_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int            CW   = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/hbus_addr_ctrl.sv
module hbus_addr_ctrl #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dr_wr,
  input  logic          dr_rd,
  input  logic [DW-1:0] wbyte,
  input  logic          ac_load,
  input  logic [AW-1:0] ac_val,
  input  logic          ac_dec,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] ac,
  output logic [DW-1:0] dr,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_re
);
  logic [AW-1:0] ac_q, ac_d, step;
  logic [DW-1:0] dr_q, dr_d;
  logic          dr_en;
  logic          pf_q, pf_d, issue;
  logic          pend_q;
  logic          we_q, re_q;
  logic [AW-1:0] addr_q;
  logic          addr_en;
  logic [DW-1:0] wdata_q;

  always_comb begin
    step    = ac_dec ? (ac_q - AW'(1)) : (ac_q + AW'(1));
    if (ac_load)            ac_d = ac_val;
    else if (dr_wr | dr_rd) ac_d = step;
    else                    ac_d = ac_q;
    // a write owns the RAM port; a pending refill waits one cycle
    issue   = pf_q & ~dr_wr;
    pf_d    = ac_load | dr_rd | (pf_q & ~issue);
    addr_en = dr_wr | issue;
    dr_en   = dr_wr | pend_q;
    dr_d    = dr_wr ? wbyte : ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q    <= '0;
      dr_q    <= '0;
      pf_q    <= 1'b0;
      pend_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ac_q   <= ac_d;
      pf_q   <= pf_d;
      pend_q <= re_q;
      we_q   <= dr_wr;
      re_q   <= issue;
      if (dr_en)   dr_q    <= dr_d;
      if (addr_en) addr_q  <= ac_q;
      if (dr_wr)   wdata_q <= wbyte;
    end
  end

  assign ac        = ac_q;
  assign dr        = dr_q;
  assign ram_addr  = addr_q;
  assign ram_we    = we_q;
  assign ram_re    = re_q;
  assign ram_wdata = wdata_q;

  a_r4_write_at_counter: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> (ram_we && ram_addr == $past(ac_q) && ram_wdata == $past(wbyte)));
  a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    ((dr_wr || dr_rd) && !ac_load && !ac_dec) |=> ac_q == $past(ac_q) + AW'(1));
  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    ((dr_wr || dr_rd) && !ac_load && ac_dec) |=> ac_q == $past(ac_q) - AW'(1));
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ac_load |=> ac_q == $past(ac_val));
  a_r5_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
endmodule

// File: rtl/hostbus_dualreg.sv
module hostbus_dualreg #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_e,
  input  logic          bus_rs,
  input  logic          bus_rw,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          ir_valid,
  output logic [DW-1:0] ir_code,
  input  logic          ac_load,
  input  logic [DW-2:0] ac_load_val,
  input  logic          ac_down,
  output logic [DW-2:0] ram_addr,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_re,
  input  logic [DW-1:0] ram_rdata,
  output logic          busy
);
  import hbus_pkg::*;

  localparam int AW = DW - 1;

  logic          rst_s;
  logic          e_hi, rs_now, rw_now, fall, cap_rs, cap_rw;
  logic [DW-1:0] cap_d;
  logic          done;
  logic [DW-1:0] byte_v, rd_byte, dout;
  acc_e          acc;
  logic          ir_wr, dr_wr, dr_rd, mode_wr;
  logic [AW-1:0] ac;
  logic [DW-1:0] dr;
  logic          busy_w;
  logic          irv_q, irv_d;
  logic [DW-1:0] irc_q;

  hbus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  hbus_strobe_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .e_in(bus_e), .rs_in(bus_rs), .rw_in(bus_rw),
    .d_in(bus_din), .e_hi(e_hi), .rs_now(rs_now), .rw_now(rw_now), .fall(fall),
    .cap_rs(cap_rs), .cap_rw(cap_rw), .cap_d(cap_d)
  );

  always_comb begin
    acc     = acc_e'({cap_rs, cap_rw});
    ir_wr   = done && (acc == ACC_IR_WR) && !busy_w;
    dr_wr   = done && (acc == ACC_DR_WR);
    dr_rd   = done && (acc == ACC_DR_RD);
    mode_wr = ir_wr && (byte_v[DW-1 -: 3] == WIDTH_CMD_TAG);
    rd_byte = rs_now ? dr : {busy_w, ac};
    irv_d   = ir_wr;
  end

  hbus_width_ctrl #(.DW(DW)) u_width (
    .clk(clk), .rst_n(rst_s), .fall(fall), .cap_d(cap_d),
    .mode_wr(mode_wr), .mode_wide(byte_v[WIDTH_BIT]), .rd_byte(rd_byte),
    .done(done), .byte_o(byte_v), .dout(dout)
  );

  hbus_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_s), .start(ir_wr), .busy(busy_w)
  );

  hbus_addr_ctrl #(.AW(AW), .DW(DW)) u_addr (
    .clk(clk), .rst_n(rst_s), .dr_wr(dr_wr), .dr_rd(dr_rd), .wbyte(byte_v),
    .ac_load(ac_load), .ac_val(ac_load_val), .ac_dec(ac_down),
    .ram_rdata(ram_rdata), .ac(ac), .dr(dr), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irv_q <= 1'b0;
      irc_q <= '0;
    end else begin
      irv_q <= irv_d;
      if (ir_wr) irc_q <= byte_v;
    end
  end

  assign ir_valid = irv_q;
  assign ir_code  = irc_q;
  assign busy     = busy_w;
  assign bus_doe  = e_hi & rw_now;
  assign bus_dout = bus_doe ? dout : '0;

  a_r2_drop_while_busy: assert property (@(posedge clk) disable iff (!rst_s)
    (done && acc == ACC_IR_WR && busy_w) |=> !ir_valid);
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_s)
    ir_valid |=> !ir_valid);
  a_r3_drive_only_high: assert property (@(posedge clk) disable iff (!rst_s)
    !e_hi |-> !bus_doe);
endmodule

// File: tb/hostbus_dualreg_test.sv
`timescale 1ns/1ps
module hostbus_dualreg_test;
  localparam int BUSY = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_e, bus_rs, bus_rw;
  logic [7:0] bus_din, bus_dout;
  logic       bus_doe, ir_valid;
  logic [7:0] ir_code;
  logic       ac_load, ac_down;
  logic [6:0] ac_load_val, ram_addr;
  logic       ram_we, ram_re, busy;
  logic [7:0] ram_wdata, ram_rdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hostbus_dualreg #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .ir_valid(ir_valid), .ir_code(ir_code), .ac_load(ac_load),
    .ac_load_val(ac_load_val), .ac_down(ac_down), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re),
    .ram_rdata(ram_rdata), .busy(busy)
  );

  // RAM model: registered read, initial content i ^ 5A
  logic [7:0] mem [128];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'h5A;
      ram_rdata <= 8'h00;
    end else begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[ram_addr];
    end
  end

  // Port monitors
  int         we_cnt = 0, ir_cnt = 0, blen = 0, last_blen = 0;
  logic [6:0] last_waddr = '0;
  logic [7:0] last_wdata = '0, last_ir = '0;
  always @(negedge clk) begin
    if (ram_we)   begin we_cnt++; last_waddr = ram_addr; last_wdata = ram_wdata; end
    if (ir_valid) begin ir_cnt++; last_ir = ir_code; end
    if (busy) blen++;
    else if (blen != 0) begin last_blen = blen; blen = 0; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic rs, input logic rw, input logic [7:0] d,
                        output logic [7:0] q, output logic oe);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_din = d; bus_e = 1'b1;
    repeat (5) @(negedge clk);
    q = bus_dout; oe = bus_doe;
    bus_e = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_load(input logic [6:0] v);
    @(negedge clk); ac_load = 1'b1; ac_load_val = v;
    @(negedge clk); ac_load = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 doe", bus_doe, 0);
    chk("R1 dout", bus_dout, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ir_valid count", ir_cnt, 0);
    begin
      logic [7:0] q; logic oe;
      strobe(1'b0, 1'b1, 8'h00, q, oe);
      chk("R1 status after reset", q, 8'h00);
    end
  endtask

  task automatic t_instr;
    logic [7:0] q; logic oe; int c0;
    c0 = ir_cnt;
    strobe(1'b0, 1'b0, 8'h38, q, oe);
    chk("R2 pulse count", ir_cnt, c0 + 1);
    chk("R2 code", last_ir, 8'h38);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R3 status busy set, code unreadable", q, 8'h80);
    chk("R3 doe while read high", oe, 1);
    chk("R3 doe after strobe low", bus_doe, 0);
    strobe(1'b0, 1'b0, 8'h01, q, oe);
    chk("R3 doe on write", oe, 0);
    chk("R2 dropped while busy", ir_cnt, c0 + 1);
    repeat (60) @(negedge clk);
    chk("R2 busy length", last_blen, BUSY);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R3 status idle", q, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] q; logic oe; int w0;
    do_load(7'h05);
    w0 = we_cnt;
    strobe(1'b1, 1'b0, 8'hA1, q, oe);
    chk("R4 one write", we_cnt, w0 + 1);
    chk("R4 addr", last_waddr, 7'h05);
    chk("R4 data", last_wdata, 8'hA1);
    strobe(1'b1, 1'b0, 8'hB2, q, oe);
    chk("R4 addr next", last_waddr, 7'h06);
    chk("R4 data next", last_wdata, 8'hB2);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R6 counter up", q, 8'h07);
  endtask

  task automatic t_read;
    logic [7:0] q; logic oe;
    do_load(7'h05);
    strobe(1'b1, 1'b1, 8'h00, q, oe);
    chk("R5 read prefetched", q, 8'hA1);
    strobe(1'b1, 1'b1, 8'h00, q, oe);
    chk("R5 read reloaded", q, 8'hB2);
    strobe(1'b1, 1'b1, 8'h00, q, oe);
    chk("R5 read third", q, 8'h07 ^ 8'h5A);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R6 counter after reads", q, 8'h08);
  endtask

  task automatic t_down;
    logic [7:0] q; logic oe;
    @(negedge clk); ac_down = 1'b1;
    do_load(7'h00);
    strobe(1'b1, 1'b0, 8'h11, q, oe);
    chk("R6 write addr before wrap", last_waddr, 7'h00);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R6 wrap down", q, 8'h7F);
    @(negedge clk); ac_down = 1'b0;
  endtask

  task automatic t_collide;
    logic [7:0] q; logic oe;
    @(negedge clk);
    bus_rs = 1'b1; bus_rw = 1'b0; bus_din = 8'h77; bus_e = 1'b1;
    repeat (5) @(negedge clk);
    bus_e = 1'b0;
    @(negedge clk);
    @(negedge clk); ac_load = 1'b1; ac_load_val = 7'h20;
    @(negedge clk); ac_load = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 write used old counter", last_waddr, 7'h7F);
    chk("R7 write data", last_wdata, 8'h77);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R7 counter took load", q, 8'h20);
    strobe(1'b1, 1'b1, 8'h00, q, oe);
    chk("R7 refill from loaded address", q, 8'h20 ^ 8'h5A);
  endtask

  task automatic t_nibble;
    logic [7:0] q; logic oe; int w0;
    strobe(1'b0, 1'b0, 8'h28, q, oe);
    chk("R8 width command accepted", last_ir, 8'h28);
    repeat (60) @(negedge clk);
    do_load(7'h10);
    w0 = we_cnt;
    strobe(1'b1, 1'b0, 8'hCF, q, oe);
    chk("R9 no write after first nibble", we_cnt, w0);
    strobe(1'b1, 1'b0, 8'h3A, q, oe);
    chk("R9 write after second nibble", we_cnt, w0 + 1);
    chk("R9 assembled data, low lines ignored", last_wdata, 8'hC3);
    chk("R9 write addr", last_waddr, 7'h10);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R9 status upper nibble", q, 8'h10);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R9 status lower nibble", q, 8'h10);
    do_load(7'h10);
    strobe(1'b1, 1'b1, 8'h00, q, oe);
    chk("R9 data upper nibble", q, 8'hC0);
    strobe(1'b1, 1'b1, 8'h00, q, oe);
    chk("R9 data lower nibble", q, 8'h30);
    strobe(1'b0, 1'b0, 8'h35, q, oe);
    strobe(1'b0, 1'b0, 8'h0F, q, oe);
    chk("R8 nibble instruction code", last_ir, 8'h30);
    strobe(1'b0, 1'b1, 8'h00, q, oe);
    chk("R8 back to 8-bit status", q, 8'h91);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_e = 1'b0; bus_rs = 1'b0; bus_rw = 1'b0; bus_din = '0;
    ac_load = 1'b0; ac_load_val = '0; ac_down = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_instr;
    t_write;
    t_read;
    t_down;
    t_collide;
    t_nibble;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule